// File: doc/BRIEF.md
# Interrupt Controller Command Interface

This block is the byte-wide programming interface of one eight-line interrupt controller core. A bus master reaches it through a one-bit address (even and odd port), separate read and write strobes, and an 8-bit data bus. Writes run a fixed four-word initialization sequence and, once the core is ready, the operation commands that load the mask, end interrupts, move the rotating priority pointer and pick what a read returns. Reads return the mask, the pending-request register or the in-service register.

The core holds the request, in-service and mask registers, the vector base, the rotation pointer and the mode flags. Pending lines are merged in from the line-handling logic through `req_set_i`. The cascade and delivery logic reports an accepted interrupt through `ack_i`. A shared priority resolver, instantiated twice, ranks lines starting just after the pointer. The core raises `irq_o` with a vector when an unmasked request outranks everything in service. A malformed initialization word, or a read while poll mode is on, produces a one-cycle `cmd_err_o` pulse.

Top module: `irqc_cmd_if`

## Requirements
- R1: After reset the core is not ready, the mask, request, in-service and base registers read zero, poll, rotate and auto-EOI are off, reads select the request register, and the pointer is 7, so line 0 has the highest priority.
- R2: An even-port write with bit 4 set begins initialization. It drops ready, clears the mask, returns the pointer to 7 and the read selection to the request register, and waits for the second word.
- R3: If that first word has bit 1 set (single mode) or bit 0 clear (no fourth word), `cmd_err_o` pulses and the sequence does not advance. Odd-port writes then load the mask.
- R4: The second word, on the odd port, sets the vector base to its value with the low three bits cleared. The third word is accepted and has no effect.
- R5: The fourth word must have bit 0 set, or `cmd_err_o` pulses and the fourth word is still awaited. When it is accepted, its bit 1 sets auto-EOI mode and the core becomes ready.
- R6: Outside the initialization sequence, an odd-port write loads the mask register.
- R7: When ready, an even-port write with bit 4 clear and bit 3 set sets poll mode from bit 2. If bit 1 is set, bit 0 selects what even-port reads return: 1 for the in-service register, 0 for the request register.
- R8: A read returns its value on `rdata_o` in the cycle after the strobe. An odd-port read returns the mask and an even-port read returns the selected register. Any read in poll mode instead pulses `cmd_err_o` and returns 0.
- R9: When ready, an even-port write with bits 4 and 3 clear and bit 5 set ends an interrupt. With bit 6 set it clears the in-service bit named by bits 2:0. With bit 6 clear it clears the highest-priority in-service bit, if there is one. If bit 7 is set, the pointer moves to the cleared line.
- R10: Such a write always stores bit 7 as the rotate flag. With bit 5 clear and bits 7 and 6 set, it loads the pointer from bits 2:0.
- R11: On `ack_i` the request bit of `ack_pin_i` is cleared unless `ack_hold_i` is high. Without auto-EOI the line's in-service bit is set. With auto-EOI the in-service register is left alone, and if rotate is on the pointer moves to that line.
- R12: `irq_o` is high when an unmasked request ranks strictly above the highest in-service line. Rank runs from the line after the pointer upward, wrapping. `irq_vec_o` is the base OR the winning line.
- R13: While the core is not ready, even-port writes with bit 4 clear have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 1 | Port select: 0 even, 1 odd |
| wdata_i | input | 8 | Write data |
| req_set_i | input | 8 | Request bits to set, one per line |
| ack_i | input | 1 | Interrupt accepted |
| ack_pin_i | input | 3 | Line being accepted |
| ack_hold_i | input | 1 | Accepted line is still active; keep its request |
| rdata_o | output | 8 | Read data, valid the cycle after `rd_i` |
| cmd_err_o | output | 1 | One-cycle command error pulse |
| ready_o | output | 1 | Initialization complete |
| irq_o | output | 1 | Eligible interrupt pending |
| irq_vec_o | output | 8 | Vector of the eligible interrupt |

## Verification
The assertions watch on every cycle that an error pulse follows only an access, that a read in poll mode always errors, that an odd-port read returns the mask, that ready changes only on the words that may change it, and that any raised interrupt names an unmasked pending line. The bench's scenarios are needed to show the step order of initialization, the base masking, the even-port read steering, end-of-interrupt with and without rotation, pointer loading and the auto-EOI path. Randomized command and acceptance mixes are compared against a reference model of the requirements.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int IRQC_N  = 8;
    localparam int IRQC_PW = $clog2(IRQC_N);
    localparam int IRQC_DW = 8;
    localparam int IRQC_SW = 3;

    // first initialization word
    localparam int B_INIT   = 4;
    localparam int B_SINGLE = 1;
    localparam int B_NEED4  = 0;
    // fourth initialization word
    localparam int B_UPMODE = 0;
    localparam int B_AUTOEO = 1;
    // operation words
    localparam int B_CTL3   = 3;
    localparam int B_ROT    = 7;
    localparam int B_SPEC   = 6;
    localparam int B_EOI    = 5;
    localparam int B_POLL   = 2;
    localparam int B_RDEN   = 1;
    localparam int B_RDISR  = 0;

    typedef enum logic [2:0] {
        K_NONE, K_INIT1, K_INIT2, K_INIT3, K_INIT4, K_MASK, K_RDCTL, K_EOICTL
    } wr_kind_e;

    typedef struct packed {
        logic                 ready;
        logic [IRQC_SW-1:0]   step;
        logic [IRQC_N-1:0]    mask;
        logic [IRQC_N-1:0]    req;
        logic [IRQC_N-1:0]    isr;
        logic [IRQC_DW-1:0]   base;
        logic [IRQC_PW-1:0]   ptr;
        logic                 aeoi;
        logic                 rotate;
        logic                 poll;
        logic                 rd_isr;
        logic [IRQC_DW-1:0]   rdata;
        logic                 err;
    } core_st_t;

endpackage

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int N  = 8,
    parameter int PW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    input  logic [PW-1:0] ptr_i,
    output logic          found_o,
    output logic [PW-1:0] pin_o,
    output logic [PW:0]   rank_o
);
    // Rank k means line (ptr + 1 + k) mod N; the lowest rank wins.
    logic [PW-1:0] idx;

    always_comb begin
        found_o = 1'b0;
        pin_o   = '0;
        rank_o  = (PW+1)'(N);
        idx     = '0;
        for (int k = N - 1; k >= 0; k--) begin
            idx = ptr_i + PW'(1) + PW'(k);
            if (vec_i[idx]) begin
                found_o = 1'b1;
                pin_o   = idx;
                rank_o  = (PW+1)'(k);
            end
        end
    end
endmodule

// File: rtl/irqc_wr_decode.sv
module irqc_wr_decode
    import irqc_pkg::*;
(
    input  logic               wr_i,
    input  logic               addr_i,
    input  logic               init_bit_i,
    input  logic               ctl3_bit_i,
    input  logic [IRQC_SW-1:0] step_i,
    input  logic               ready_i,
    output wr_kind_e           kind_o
);
    always_comb begin
        kind_o = K_NONE;
        if (wr_i) begin
            if (addr_i) begin
                case (step_i)
                    IRQC_SW'(2): kind_o = K_INIT2;
                    IRQC_SW'(3): kind_o = K_INIT3;
                    IRQC_SW'(4): kind_o = K_INIT4;
                    default:     kind_o = K_MASK;
                endcase
            end else if (init_bit_i) begin
                kind_o = K_INIT1;
            end else if (ready_i) begin
                kind_o = ctl3_bit_i ? K_RDCTL : K_EOICTL;
            end
        end
    end
endmodule

// File: rtl/irqc_cmd_if.sv
module irqc_cmd_if
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic               rd_i,
    input  logic               addr_i,
    input  logic [IRQC_DW-1:0] wdata_i,
    input  logic [IRQC_N-1:0]  req_set_i,
    input  logic               ack_i,
    input  logic [IRQC_PW-1:0] ack_pin_i,
    input  logic               ack_hold_i,
    output logic [IRQC_DW-1:0] rdata_o,
    output logic               cmd_err_o,
    output logic               ready_o,
    output logic               irq_o,
    output logic [IRQC_DW-1:0] irq_vec_o
);
    localparam int N  = IRQC_N;
    localparam int PW = IRQC_PW;

    core_st_t st_q, st_d;
    wr_kind_e kind;

    logic [N-1:0]  mask_q, req_q, isr_q;
    logic          poll_q;
    logic          isr_found, req_found;
    logic [PW-1:0] isr_pin, req_pin;
    logic [PW:0]   isr_rank, req_rank;
    logic [PW-1:0] eoi_pin;
    logic          eoi_hit;

    assign mask_q = st_q.mask;
    assign req_q  = st_q.req;
    assign isr_q  = st_q.isr;
    assign poll_q = st_q.poll;

    irqc_wr_decode u_dec (
        .wr_i       (wr_i),
        .addr_i     (addr_i),
        .init_bit_i (wdata_i[B_INIT]),
        .ctl3_bit_i (wdata_i[B_CTL3]),
        .step_i     (st_q.step),
        .ready_i    (st_q.ready),
        .kind_o     (kind)
    );

    irqc_prio #(.N(N), .PW(PW)) u_isr_prio (
        .vec_i   (st_q.isr),
        .ptr_i   (st_q.ptr),
        .found_o (isr_found),
        .pin_o   (isr_pin),
        .rank_o  (isr_rank)
    );

    irqc_prio #(.N(N), .PW(PW)) u_req_prio (
        .vec_i   (st_q.req & ~st_q.mask),
        .ptr_i   (st_q.ptr),
        .found_o (req_found),
        .pin_o   (req_pin),
        .rank_o  (req_rank)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        eoi_pin  = '0;
        eoi_hit  = 1'b0;

        case (kind)
            K_INIT1: begin
                st_d.ready  = 1'b0;
                st_d.step   = IRQC_SW'(1);
                st_d.mask   = '0;
                st_d.ptr    = PW'(N - 1);
                st_d.rd_isr = 1'b0;
                if (wdata_i[B_SINGLE] || !wdata_i[B_NEED4])
                    st_d.err = 1'b1;
                else
                    st_d.step = IRQC_SW'(2);
            end
            K_INIT2: begin
                st_d.base = {wdata_i[IRQC_DW-1:PW], {PW{1'b0}}};
                st_d.step = IRQC_SW'(3);
            end
            K_INIT3: begin
                st_d.step = IRQC_SW'(4);
            end
            K_INIT4: begin
                if (!wdata_i[B_UPMODE]) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.aeoi  = wdata_i[B_AUTOEO];
                    st_d.step  = '0;
                    st_d.ready = 1'b1;
                end
            end
            K_MASK: begin
                st_d.mask = wdata_i[N-1:0];
            end
            K_RDCTL: begin
                st_d.poll = wdata_i[B_POLL];
                if (wdata_i[B_RDEN])
                    st_d.rd_isr = wdata_i[B_RDISR];
            end
            K_EOICTL: begin
                st_d.rotate = wdata_i[B_ROT];
                if (wdata_i[B_EOI]) begin
                    if (wdata_i[B_SPEC]) begin
                        eoi_pin = wdata_i[PW-1:0];
                        eoi_hit = 1'b1;
                    end else begin
                        eoi_pin = isr_pin;
                        eoi_hit = isr_found;
                    end
                    if (eoi_hit) begin
                        st_d.isr[eoi_pin] = 1'b0;
                        if (wdata_i[B_ROT])
                            st_d.ptr = eoi_pin;
                    end
                end else if (wdata_i[B_SPEC] && wdata_i[B_ROT]) begin
                    st_d.ptr = wdata_i[PW-1:0];
                end
            end
            default: ;
        endcase

        if (rd_i) begin
            if (st_q.poll) begin
                st_d.err   = 1'b1;
                st_d.rdata = '0;
            end else if (addr_i) begin
                st_d.rdata = IRQC_DW'(st_q.mask);
            end else begin
                st_d.rdata = IRQC_DW'(st_q.rd_isr ? st_q.isr : st_q.req);
            end
        end

        if (ack_i) begin
            if (!ack_hold_i)
                st_d.req[ack_pin_i] = 1'b0;
            if (st_q.aeoi) begin
                if (st_q.rotate)
                    st_d.ptr = ack_pin_i;
            end else begin
                st_d.isr[ack_pin_i] = 1'b1;
            end
        end

        st_d.req = st_d.req | req_set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.ptr <= PW'(N - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o   = st_q.rdata;
    assign cmd_err_o = st_q.err;
    assign ready_o   = st_q.ready;
    assign irq_o     = req_found && (req_rank < isr_rank);
    assign irq_vec_o = st_q.base | IRQC_DW'(req_pin);

endmodule

// File: rtl/irqc_cmd_if_chk.sv
module irqc_cmd_if_chk
    import irqc_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               wr_i,
    input logic               rd_i,
    input logic               addr_i,
    input logic               init_bit,
    input logic [IRQC_DW-1:0] rdata_o,
    input logic               cmd_err_o,
    input logic               ready_o,
    input logic               irq_o,
    input logic [IRQC_PW-1:0] irq_pin,
    input logic [IRQC_N-1:0]  mask_q,
    input logic [IRQC_N-1:0]  req_q,
    input logic               poll_q
);
    // R3
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err_o |-> $past(wr_i || rd_i));

    // R8
    poll_read_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && poll_q) |=> cmd_err_o);

    // R8
    mask_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && addr_i && !poll_q) |=> (rdata_o == IRQC_DW'($past(mask_q))));

    // R12
    irq_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (req_q[irq_pin] && !mask_q[irq_pin]));

    // R5
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(wr_i && addr_i));

    // R2
    ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_o) |-> $past(wr_i && !addr_i && init_bit));
endmodule

bind irqc_cmd_if irqc_cmd_if_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (wr_i),
    .rd_i      (rd_i),
    .addr_i    (addr_i),
    .init_bit  (wdata_i[irqc_pkg::B_INIT]),
    .rdata_o   (rdata_o),
    .cmd_err_o (cmd_err_o),
    .ready_o   (ready_o),
    .irq_o     (irq_o),
    .irq_pin   (irq_vec_o[irqc_pkg::IRQC_PW-1:0]),
    .mask_q    (mask_q),
    .req_q     (req_q),
    .poll_q    (poll_q)
);

// File: tb/irqc_cmd_if_bench.sv
`timescale 1ns/1ps
module irqc_cmd_if_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_i = 1'b0, rd_i = 1'b0, addr_i = 1'b0;
    logic [7:0] wdata_i = '0, req_set_i = '0;
    logic       ack_i = 1'b0, ack_hold_i = 1'b0;
    logic [2:0] ack_pin_i = '0;
    logic [7:0] rdata_o, irq_vec_o;
    logic       cmd_err_o, ready_o, irq_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference model state
    logic       m_ready, m_aeoi, m_rot, m_poll, m_risr;
    logic [2:0] m_step, m_ptr;
    logic [7:0] m_mask, m_req, m_isr, m_base;
    logic       m_err;

    always #4 clk = ~clk;

    irqc_cmd_if u_irqc_cmd_if (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .req_set_i(req_set_i), .ack_i(ack_i),
        .ack_pin_i(ack_pin_i), .ack_hold_i(ack_hold_i), .rdata_o(rdata_o),
        .cmd_err_o(cmd_err_o), .ready_o(ready_o), .irq_o(irq_o),
        .irq_vec_o(irq_vec_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] top_isr();
        logic [2:0] p;
        top_isr = 3'd0;
        for (int k = 7; k >= 0; k--) begin
            p = m_ptr + 3'd1 + 3'(k);
            if (m_isr[p]) top_isr = p;
        end
    endfunction

    task automatic m_eval(output logic v, output logic [2:0] pin);
        int ir = 8, rr = 8;
        logic [2:0] p;
        pin = 3'd0;
        for (int k = 0; k < 8; k++) begin
            p = m_ptr + 3'd1 + 3'(k);
            if (m_isr[p] && ir == 8) ir = k;
            if (m_req[p] && !m_mask[p] && rr == 8) begin rr = k; pin = p; end
        end
        v = (rr < ir);
    endtask

    task automatic chk_irq(input string tag);
        logic v; logic [2:0] p;
        m_eval(v, p);
        chk({tag, " irq"}, {7'd0, irq_o}, {7'd0, v});
        if (v) chk({tag, " vec"}, irq_vec_o, m_base | {5'd0, p});
        chk("R5 ready", {7'd0, ready_o}, {7'd0, m_ready});
    endtask

    task automatic m_write(input logic a, input logic [7:0] d);
        logic [2:0] ep; logic hit;
        m_err = 1'b0;
        if (a) begin
            if (m_step == 3'd2) begin m_base = d & 8'hF8; m_step = 3'd3; end
            else if (m_step == 3'd3) m_step = 3'd4;
            else if (m_step == 3'd4) begin
                if (!d[0]) m_err = 1'b1;
                else begin m_aeoi = d[1]; m_step = 3'd0; m_ready = 1'b1; end
            end else m_mask = d;
        end else if (d[4]) begin
            m_ready = 1'b0; m_step = 3'd1; m_mask = '0; m_ptr = 3'd7; m_risr = 1'b0;
            if (d[1] || !d[0]) m_err = 1'b1; else m_step = 3'd2;
        end else if (m_ready) begin
            if (d[3]) begin
                m_poll = d[2];
                if (d[1]) m_risr = d[0];
            end else begin
                m_rot = d[7];
                if (d[5]) begin
                    if (d[6]) begin ep = d[2:0]; hit = 1'b1; end
                    else begin ep = top_isr(); hit = (m_isr != 0); end
                    if (hit) begin
                        m_isr[ep] = 1'b0;
                        if (d[7]) m_ptr = ep;
                    end
                end else if (d[6] && d[7]) m_ptr = d[2:0];
            end
        end
    endtask

    task automatic do_wr(input string tag, input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_i = 1'b0;
        m_write(a, d);
        chk({tag, " err"}, {7'd0, cmd_err_o}, {7'd0, m_err});
    endtask

    task automatic do_rd(input string tag, input logic a);
        logic [7:0] e;
        @(negedge clk);
        rd_i = 1'b1; addr_i = a;
        @(negedge clk);
        rd_i = 1'b0;
        if (m_poll) e = 8'h00;
        else if (a) e = m_mask;
        else e = m_risr ? m_isr : m_req;
        chk({tag, " rdata"}, rdata_o, e);
        chk({tag, " rerr"}, {7'd0, cmd_err_o}, {7'd0, m_poll});
    endtask

    task automatic do_req(input logic [7:0] v);
        @(negedge clk);
        req_set_i = v;
        @(negedge clk);
        req_set_i = '0;
        m_req = m_req | v;
    endtask

    task automatic do_ack(input logic [2:0] p, input logic hold);
        @(negedge clk);
        ack_i = 1'b1; ack_pin_i = p; ack_hold_i = hold;
        @(negedge clk);
        ack_i = 1'b0; ack_hold_i = 1'b0;
        if (!hold) m_req[p] = 1'b0;
        if (m_aeoi) begin if (m_rot) m_ptr = p; end
        else m_isr[p] = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        m_ready = 0; m_aeoi = 0; m_rot = 0; m_poll = 0; m_risr = 0; m_err = 0;
        m_step = 0; m_ptr = 3'd7; m_mask = 0; m_req = 0; m_isr = 0; m_base = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", {7'd0, ready_o}, 8'd0);
        chk("R1 irq", {7'd0, irq_o}, 8'd0);
        chk("R1 err", {7'd0, cmd_err_o}, 8'd0);
        chk("R1 rdata", rdata_o, 8'd0);
        do_rd("R1 mask", 1'b1);
        // R13 even-port command ignored before ready
        do_req(8'h05);
        do_wr("R13 ocw", 1'b0, 8'h0B);
        do_rd("R13 read", 1'b0);
        chk("R13 literal", rdata_o, 8'h05);
        // R3 bad first words
        do_wr("R3 single", 1'b0, 8'h13);
        do_wr("R3 no4", 1'b0, 8'h10);
        do_wr("R3 mask", 1'b1, 8'h55);
        do_rd("R3 maskrd", 1'b1);
        chk("R3 literal", rdata_o, 8'h55);
        // R2 good init
        do_wr("R2 init1", 1'b0, 8'h11);
        do_rd("R2 maskclr", 1'b1);
        chk("R2 literal", rdata_o, 8'h00);
        do_wr("R4 init2", 1'b1, 8'h6F);
        do_wr("R4 init3", 1'b1, 8'h04);
        do_wr("R5 bad4", 1'b1, 8'h00);
        chk("R5 notready", {7'd0, ready_o}, 8'd0);
        do_wr("R5 init4", 1'b1, 8'h01);
        chk("R5 ready", {7'd0, ready_o}, 8'd1);
        chk_irq("R12 first");
        chk("R4 vec", irq_vec_o, 8'h68);
        // R11 accept line 0
        do_ack(3'd0, 1'b0);
        chk_irq("R11 after ack");
        do_wr("R7 sel isr", 1'b0, 8'h0B);
        do_rd("R7 isr", 1'b0);
        chk("R7 literal", rdata_o, 8'h01);
        do_wr("R7 sel irr", 1'b0, 8'h0A);
        do_rd("R7 irr", 1'b0);
        // R9 non-specific EOI
        do_wr("R9 ns eoi", 1'b0, 8'h20);
        chk_irq("R9 ns");
        do_ack(3'd2, 1'b0);
        do_req(8'h03);
        chk_irq("R12 nested");
        do_wr("R9 sp eoi", 1'b0, 8'h62);
        do_wr("R9 sel isr", 1'b0, 8'h0B);
        do_rd("R9 isr", 1'b0);
        chk("R9 literal", rdata_o, 8'h00);
        // R10 pointer load
        do_wr("R10 ptr", 1'b0, 8'hC4);
        do_req(8'h40);
        chk_irq("R10 rot");
        chk("R10 literal", irq_vec_o, 8'h6E);
        do_ack(3'd6, 1'b1);
        do_wr("R9 rot eoi", 1'b0, 8'hA0);
        do_req(8'h80);
        chk_irq("R9 rot");
        // R8 poll read error
        do_wr("R8 poll on", 1'b0, 8'h0C);
        do_rd("R8 poll", 1'b0);
        do_wr("R8 poll off", 1'b0, 8'h08);
        do_rd("R8 mask", 1'b1);
        // R11 auto-EOI path
        do_wr("R2 reinit", 1'b0, 8'h11);
        do_wr("R4 base2", 1'b1, 8'h20);
        do_wr("R4 w3", 1'b1, 8'h00);
        do_wr("R5 aeoi", 1'b1, 8'h03);
        do_wr("R10 rot on", 1'b0, 8'h80);
        do_ack(3'd3, 1'b0);
        chk_irq("R11 aeoi");
        do_wr("R11 sel isr", 1'b0, 8'h0B);
        do_rd("R11 isr", 1'b0);
        // random mix
        for (int i = 0; i < 500; i++) begin
            int op;
            logic v; logic [2:0] p;
            op = int'($urandom_range(0, 7));
            case (op)
                0: do_req(8'($urandom) & 8'($urandom));
                1: do_wr("R6 rnd mask", 1'b1, 8'($urandom) & 8'($urandom));
                2: begin
                    m_eval(v, p);
                    if (v) do_ack(p, 1'($urandom));
                end
                3: do_wr("R9 rnd eoi", 1'b0, {1'($urandom), 1'($urandom), 1'b1, 2'b00, 3'($urandom)});
                4: do_wr("R10 rnd pri", 1'b0, {1'($urandom), 1'($urandom), 1'b0, 2'b00, 3'($urandom)});
                5: do_wr("R7 rnd sel", 1'b0, {4'b0000, 1'b1, 1'b0, 1'($urandom), 1'($urandom)});
                6: do_rd("R8 rnd rd", 1'($urandom));
                default: if ($urandom_range(0, 9) == 0) begin
                    do_wr("R8 rnd poll", 1'b0, 8'h0C);
                    do_rd("R8 rnd pollrd", 1'b0);
                    do_wr("R8 rnd unpoll", 1'b0, 8'h08);
                end
            endcase
            chk_irq("R12 rnd");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule